// File: doc/BRIEF.md
# Single-Cycle 16-bit Substitution-Permutation Cipher

This block encrypts one 16-bit word under a 64-bit key in a single clock cycle. Four regular rounds and a closing round are laid out as one combinational path. A register at the end captures the result. The surrounding logic presents a word, the key and a strobe. On the next clock the ciphertext appears with a valid flag.

Every 4-bit slice of the word passes through the same substitution table. The diffusion step XORs the word with two left rotations of itself. Because the register is the only state, a new word can be accepted on every clock.

Top module: `spn16_core`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 16'h0000.
- R2: `out_valid` is high in the cycle after a clock edge that sampled `in_valid` high, and low after an edge that sampled it low.
- R3: After an edge that sampled `in_valid` low, `out_data` keeps its previous value, whatever `in_data` and `in_key` carry.
- R4: The substitution step replaces each nibble x (0..F) with 2,E,F,5,C,1,9,A,B,4,6,8,0,7,3,D respectively. The same table is used in all four nibble positions.
- R5: The diffusion step maps m to m XOR rotl(m,6) XOR rotl(m,10) on 16 bits.
- R6: The key is split into words W0=`in_key[15:0]`, W1=`[31:16]`, W2=`[47:32]` and W3=`[63:48]`. Regular round r (r=0..3) XORs in Wr, then substitutes, then diffuses.
- R7: The closing round XORs W0, substitutes, and XORs W1. It has no diffusion step.
- R8: Words presented on consecutive cycles each produce their own ciphertext on the following cycle, with no bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: encrypt `in_data` this cycle |
| in_data | input | 16 | Plaintext word |
| in_key | input | 64 | Cipher key, four 16-bit words |
| out_valid | output | 1 | Result register holds a fresh ciphertext |
| out_data | output | 16 | Registered ciphertext |

## Verification
In one cycle the register can present the ciphertext of the previous word while the cipher path computes the next one. The register can also be told to hold its result while its inputs keep changing. The bench streams all 65536 plaintexts back to back under one key, so every cycle both captures and presents a result. Each output is compared with a bench model of the rounds. Gaps with random data and keys driven while the strobe is low then show that the held result and the valid flag do not move.

// File: rtl/spn16_pkg.sv
package spn16_pkg;
  localparam int BLK_W  = 16;
  localparam int NIB_W  = 4;
  localparam int NIB_N  = BLK_W / NIB_W;
  localparam int KEY_W  = 64;
  localparam int RK_N   = KEY_W / BLK_W;
  localparam int ROT_A  = 6;
  localparam int ROT_B  = 10;

  // shared 4-bit substitution table (R4)
  function automatic logic [NIB_W-1:0] sbox4(input logic [NIB_W-1:0] x);
    logic [NIB_W-1:0] y;
    case (x)
      4'h0: y = 4'h2;  4'h1: y = 4'hE;  4'h2: y = 4'hF;  4'h3: y = 4'h5;
      4'h4: y = 4'hC;  4'h5: y = 4'h1;  4'h6: y = 4'h9;  4'h7: y = 4'hA;
      4'h8: y = 4'hB;  4'h9: y = 4'h4;  4'hA: y = 4'h6;  4'hB: y = 4'h8;
      4'hC: y = 4'h0;  4'hD: y = 4'h7;  4'hE: y = 4'h3;  default: y = 4'hD;
    endcase
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] rotl(input logic [BLK_W-1:0] m, input int s);
    return (m << s) | (m >> (BLK_W - s));
  endfunction

  // rotate-XOR diffusion (R5)
  function automatic logic [BLK_W-1:0] diffuse(input logic [BLK_W-1:0] m);
    return m ^ rotl(m, ROT_A) ^ rotl(m, ROT_B);
  endfunction
endpackage

// File: rtl/spn16_sub_layer.sv
module spn16_sub_layer
  import spn16_pkg::*;
(
  input  logic [BLK_W-1:0] x,
  output logic [BLK_W-1:0] y
);
  for (genvar i = 0; i < NIB_N; i++) begin : g_nib
    assign y[i*NIB_W +: NIB_W] = sbox4(x[i*NIB_W +: NIB_W]);
  end
endmodule

// File: rtl/spn16_round.sv
module spn16_round
  import spn16_pkg::*;
(
  input  logic [BLK_W-1:0] x,
  input  logic [BLK_W-1:0] rk,
  output logic [BLK_W-1:0] y
);
  logic [BLK_W-1:0] mixed;
  logic [BLK_W-1:0] subst;

  assign mixed = x ^ rk;
  spn16_sub_layer u_sub (.x(mixed), .y(subst));
  assign y = diffuse(subst);
endmodule

// File: rtl/spn16_last_round.sv
module spn16_last_round
  import spn16_pkg::*;
(
  input  logic [BLK_W-1:0] x,
  input  logic [BLK_W-1:0] rk_in,
  input  logic [BLK_W-1:0] rk_out,
  output logic [BLK_W-1:0] y
);
  logic [BLK_W-1:0] mixed;
  logic [BLK_W-1:0] subst;

  assign mixed = x ^ rk_in;
  spn16_sub_layer u_sub (.x(mixed), .y(subst));
  assign y = subst ^ rk_out;
endmodule

// File: rtl/spn16_datapath.sv
module spn16_datapath
  import spn16_pkg::*;
(
  input  logic [BLK_W-1:0] pt,
  input  logic [KEY_W-1:0] key,
  output logic [BLK_W-1:0] ct
);
  logic [BLK_W-1:0] stage [RK_N+1];

  assign stage[0] = pt;

  for (genvar r = 0; r < RK_N; r++) begin : g_round
    spn16_round u_rnd (
      .x  (stage[r]),
      .rk (key[r*BLK_W +: BLK_W]),
      .y  (stage[r+1])
    );
  end

  spn16_last_round u_last (
    .x      (stage[RK_N]),
    .rk_in  (key[0 +: BLK_W]),
    .rk_out (key[BLK_W +: BLK_W]),
    .y      (ct)
  );
endmodule

// File: rtl/spn16_core.sv
module spn16_core
  import spn16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [15:0]      in_data,
  input  logic [63:0]      in_key,
  output logic             out_valid,
  output logic [15:0]      out_data
);
  logic [BLK_W-1:0] cipher_w;

  spn16_datapath u_dp (
    .pt  (in_data),
    .key (in_key),
    .ct  (cipher_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= cipher_w;
    end
  end
endmodule

// File: rtl/spn16_chk.sv
module spn16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [15:0] out_data,
  input logic [15:0] cipher_comb
);
  // R1: reset clears the output register
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_data == 16'h0000));

  // R2: valid follows the strobe by one cycle
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: result is held while no strobe
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R8: each strobed word lands in the register on the next cycle
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data == $past(cipher_comb)));
endmodule

bind spn16_core spn16_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .cipher_comb (cipher_w)
);

// File: tb/sim_spn16_core.sv
module sim_spn16_core;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [63:0] in_key = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic        exp_v = 1'b0;
  logic [15:0] exp_d = '0;
  string       exp_tag = "R1";

  localparam logic [3:0] SUBTAB [16] = '{4'h2, 4'hE, 4'hF, 4'h5, 4'hC, 4'h1, 4'h9, 4'hA,
                                         4'hB, 4'h4, 4'h6, 4'h8, 4'h0, 4'h7, 4'h3, 4'hD};

  spn16_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_key(in_key), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] subst(input logic [15:0] v);
    return {SUBTAB[v[15:12]], SUBTAB[v[11:8]], SUBTAB[v[7:4]], SUBTAB[v[3:0]]};
  endfunction

  // reference model: R4 table, R5 rotations, R6 key order, R7 closing round
  function automatic logic [15:0] ref_enc(input logic [15:0] d, input logic [63:0] k);
    logic [15:0] x, t;
    x = d;
    for (int r = 0; r < 4; r++) begin
      t = subst(x ^ k[16*r +: 16]);
      x = t ^ {t[9:0], t[15:10]} ^ {t[5:0], t[15:6]};
    end
    return subst(x ^ k[15:0]) ^ k[31:16];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare what the previous drive should have produced, then drive anew
  task automatic step(input logic v, input logic [15:0] d, input logic [63:0] k, input string tag);
    @(negedge clk);
    chk(out_valid == exp_v, "R2 valid", {63'd0, out_valid}, {63'd0, exp_v});
    chk(out_data == exp_d, exp_tag, {48'd0, out_data}, {48'd0, exp_d});
    exp_v = v;
    if (v) exp_d = ref_enc(d, k);
    exp_tag = tag;
    in_valid = v;
    in_data  = d;
    in_key   = k;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] keys [6];
    keys[0] = 64'h0;
    keys[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    keys[2] = 64'h0000_0000_0000_A5C3;
    keys[3] = 64'h0000_0000_3C5A_0000;
    keys[4] = 64'h0000_9E37_0000_0000;
    keys[5] = 64'h71D4_0000_0000_0000;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 valid", {63'd0, out_valid}, 64'd0);
    chk(out_data == 16'h0, "R1 data", {48'd0, out_data}, 64'd0);
    rst_n = 1'b1;

    // R8 with R4 R5 R6 R7: exhaustive back-to-back sweep under one key
    for (int i = 0; i < 65536; i++)
      step(1'b1, i[15:0], 64'h0123_4567_89AB_CDEF, "R8 sweep R4 R5 R6 R7");

    // R6 key word order: one key word at a time, plus extremes
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < 256; i++)
        step(1'b1, 16'(i * 16'h0101 + j), keys[j], "R6 key words R7");

    // R3 with R2: hold under changing inputs, gapped strobes
    for (int j = 0; j < 40; j++) begin
      step(1'b1, 16'($urandom), {$urandom, $urandom}, "R3 capture");
      for (int g = 0; g < (j % 4) + 1; g++)
        step(1'b0, 16'($urandom), {$urandom, $urandom}, "R3 hold");
    end
    step(1'b0, 16'h0, 64'h0, "R3 hold");
    step(1'b0, 16'h0, 64'h0, "R3 hold");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule